// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block stands in front of the array read path of a parallel NOR flash. It models what the host sees while an internal program or erase is running. Program and erase start commands come in on a valid/ready command stream. Each command carries an address, a data byte and a sector-select mask. A static per-sector protection map comes in as well. While an operation is busy, a read at a polled address returns an 8-bit status byte instead of array data. Bit 7 of that byte is the data-polling bit. Every other read returns the array byte that the surrounding logic supplies for the read address.

Operation durations are counted in microsecond ticks set by parameters, so a testbench can shorten them. A running erase can be suspended and resumed. While the erase is suspended, a program may run. Sector index is the top `SECT_W` bits of an address, and bit n of a sector mask refers to sector n.

The stream rules are as follows. A command transfers on a cycle where `cmd_valid` and `cmd_ready` are both high. A read request transfers when `rd_valid` and `rd_ready` are both high. The response appears on `rsp_valid`/`rsp_data` one cycle later. A response that is not taken stays unchanged until `rsp_ready` is high, and no new read is accepted until it is taken. `cmd_ready` does not depend on `cmd_valid`.

Top module: `nor_busy_status`

## Requirements
- R1: After reset, `dev_ready`, `cmd_ready` and `rd_ready` are high and `rsp_valid` is low.
- R2: A command takes effect in the cycle after its transfer. A read that transfers in the same cycle as a command returns `arr_data`.
- R3: While a program is active, a read at the program address returns a status byte: bit 7 is the inverse of bit 7 of the program data, and bits 6:0 are 0. Reads at other addresses return `arr_data`.
- R4: A program to an unprotected sector stays active for `PROG_US` ticks, counted from the cycle after its transfer. After that, every read returns `arr_data`.
- R5: A program whose sector has its `prot_map` bit set shows the same status as R3 for `PROT_PROG_US` ticks, then ends.
- R6: An erase polls only the sectors that are selected and not protected. Reads there return 8'h00 for `ERASE_US` ticks.
- R7: An erase in which no selected sector is unprotected returns 8'h00 on all selected sectors for `PROT_ERASE_US` ticks. A suspend request has no effect on it.
- R8: During a partly protected erase, reads in the protected selected sectors return `arr_data`.
- R9: A suspend request during a running erase stops the erase count from the next cycle. Erased sectors then read 8'h80, and `dev_ready` and `cmd_ready` go high. If the erase ends on the same edge, the end wins.
- R10: A program transferred during suspend behaves as in R3 to R5. An erase command transferred during suspend is consumed with no effect.
- R11: A resume request while the erase is suspended, no program is active and no command transfers resumes the erase with its remaining ticks.
- R12: `dev_ready` is low exactly while a program is active or an erase is running (not suspended). `cmd_ready` follows `dev_ready`.
- R13: `rd_ready` is high when no response is pending or the pending one is taken. A pending response holds its data until it is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| prot_map | input | NSECT | Per-sector protection |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command ready |
| cmd_op | input | 1 | 0 program, 1 erase |
| cmd_addr | input | ADDR_W | Program address |
| cmd_data | input | 8 | Program data |
| cmd_sect | input | NSECT | Erase sector select |
| suspend_req | input | 1 | Erase suspend pulse |
| resume_req | input | 1 | Erase resume pulse |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request ready |
| rd_addr | input | ADDR_W | Read address |
| arr_data | input | 8 | Array byte for `rd_addr` |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response ready |
| rsp_data | output | 8 | Read response byte |
| dev_ready | output | 1 | High when not busy |

## Verification
The checker enforces the following on every cycle:
- the idle state after reset;
- going busy after a program transfers;
- the inverted polling bit at the program address;
- the zero status in a running erase sector;
- a frozen erase count during suspend;
- response hold under back-pressure.

Some behaviours show only in the bench's scenarios against its reference model:
- the exact tick count of each operation;
- the protected timeouts;
- skipped protected sectors;
- the ignored suspend on a protected-only erase;
- the consumed erase during suspend;
- resume priority against a command.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  typedef enum logic [1:0] {
    E_IDLE = 2'd0,
    E_RUN  = 2'd1,
    E_SUSP = 2'd2
  } erase_state_e;

  localparam logic OP_PROG  = 1'b0;
  localparam logic OP_ERASE = 1'b1;

  localparam logic [7:0] ST_ERASE_BUSY = 8'h00;
  localparam logic [7:0] ST_ERASE_SUSP = 8'h80;

  function automatic logic [7:0] prog_status(input logic [7:0] d);
    return {~d[7], 7'b0};
  endfunction
endpackage

// File: rtl/nbs_tick_timer.sv
module nbs_tick_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (step && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = step && (cnt == CNT_W'(1));
endmodule

// File: rtl/nbs_op_ctrl.sv
module nbs_op_ctrl
  import nbs_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int SECT_W        = 3,
  parameter int PROG_US       = 9,
  parameter int PROT_PROG_US  = 1,
  parameter int ERASE_US      = 700,
  parameter int PROT_ERASE_US = 100,
  parameter int PW            = 4,
  parameter int EW            = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic [(1<<SECT_W)-1:0] prot_map,
  input  logic              cmd_valid,
  input  logic              cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [(1<<SECT_W)-1:0] cmd_sect,
  input  logic              suspend_req,
  input  logic              resume_req,
  input  logic              prog_expire,
  input  logic              erase_expire,
  output logic              cmd_ready,
  output logic              dev_ready,
  output logic              prog_act,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output erase_state_e      erase_st,
  output logic [(1<<SECT_W)-1:0] erase_mask,
  output logic              erase_all_prot,
  output logic              prog_load,
  output logic [PW-1:0]     prog_load_val,
  output logic              prog_step,
  output logic              erase_load,
  output logic [EW-1:0]     erase_load_val,
  output logic              erase_step
);
  localparam int NSECT = 1 << SECT_W;

  logic              accept;
  logic              take_prog;
  logic              take_erase;
  logic [SECT_W-1:0] cmd_sec;
  logic [NSECT-1:0]  eff_sect;
  logic              none_eff;
  logic              go_susp;
  logic              go_resume;

  assign cmd_ready  = !prog_act && (erase_st != E_RUN);
  assign dev_ready  = cmd_ready;
  assign accept     = cmd_valid && cmd_ready;
  assign take_prog  = accept && (cmd_op == OP_PROG);
  assign take_erase = accept && (cmd_op == OP_ERASE) && (erase_st == E_IDLE);
  assign cmd_sec    = cmd_addr[ADDR_W-1 -: SECT_W];
  assign eff_sect   = cmd_sect & ~prot_map;
  assign none_eff   = (eff_sect == '0);

  assign go_susp   = (erase_st == E_RUN) && !erase_all_prot && suspend_req && !erase_expire;
  assign go_resume = (erase_st == E_SUSP) && !prog_act && resume_req && !accept;

  assign prog_load     = take_prog;
  assign prog_load_val = prot_map[cmd_sec] ? PW'(PROT_PROG_US) : PW'(PROG_US);
  assign prog_step     = prog_act && us_tick;

  assign erase_load     = take_erase;
  assign erase_load_val = none_eff ? EW'(PROT_ERASE_US) : EW'(ERASE_US);
  assign erase_step     = (erase_st == E_RUN) && us_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_act  <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
    end else if (take_prog) begin
      prog_act  <= 1'b1;
      prog_addr <= cmd_addr;
      prog_data <= cmd_data;
    end else if (prog_expire) begin
      prog_act  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      erase_st       <= E_IDLE;
      erase_mask     <= '0;
      erase_all_prot <= 1'b0;
    end else begin
      if (take_erase) begin
        erase_st       <= E_RUN;
        erase_mask     <= none_eff ? cmd_sect : eff_sect;
        erase_all_prot <= none_eff;
      end else if (erase_expire) begin
        erase_st <= E_IDLE;
      end else if (go_susp) begin
        erase_st <= E_SUSP;
      end else if (go_resume) begin
        erase_st <= E_RUN;
      end
    end
  end
endmodule

// File: rtl/nbs_read_port.sv
module nbs_read_port
  import nbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_act,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [7:0]        prog_data,
  input  erase_state_e      erase_st,
  input  logic [(1<<SECT_W)-1:0] erase_mask,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_data,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data
);
  localparam int NSECT = 1 << SECT_W;

  logic [NSECT-1:0]  sec_hot;
  logic              in_erase;
  logic [7:0]        sel_byte;

  for (genvar s = 0; s < NSECT; s++) begin : g_sec
    assign sec_hot[s] = (rd_addr[ADDR_W-1 -: SECT_W] == SECT_W'(s)) && erase_mask[s];
  end

  assign in_erase = |sec_hot;

  always_comb begin
    if (prog_act && rd_addr == prog_addr) begin
      sel_byte = prog_status(prog_data);
    end else if (erase_st == E_RUN && in_erase) begin
      sel_byte = ST_ERASE_BUSY;
    end else if (erase_st == E_SUSP && in_erase) begin
      sel_byte = ST_ERASE_SUSP;
    end else begin
      sel_byte = arr_data;
    end
  end

  assign rd_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_valid && rd_ready) begin
      rsp_valid <= 1'b1;
      rsp_data  <= sel_byte;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/nor_busy_status.sv
module nor_busy_status
  import nbs_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int SECT_W        = 3,
  parameter int PROG_US       = 9,
  parameter int PROT_PROG_US  = 1,
  parameter int ERASE_US      = 700,
  parameter int PROT_ERASE_US = 100
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   us_tick,
  input  logic [(1<<SECT_W)-1:0] prot_map,
  input  logic                   cmd_valid,
  output logic                   cmd_ready,
  input  logic                   cmd_op,
  input  logic [ADDR_W-1:0]      cmd_addr,
  input  logic [7:0]             cmd_data,
  input  logic [(1<<SECT_W)-1:0] cmd_sect,
  input  logic                   suspend_req,
  input  logic                   resume_req,
  input  logic                   rd_valid,
  output logic                   rd_ready,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [7:0]             arr_data,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [7:0]             rsp_data,
  output logic                   dev_ready
);
  localparam int NSECT  = 1 << SECT_W;
  localparam int PMAX   = (PROG_US > PROT_PROG_US) ? PROG_US : PROT_PROG_US;
  localparam int EMAX   = (ERASE_US > PROT_ERASE_US) ? ERASE_US : PROT_ERASE_US;
  localparam int PW     = $clog2(PMAX + 1);
  localparam int EW     = $clog2(EMAX + 1);

  logic              prog_act;
  logic [ADDR_W-1:0] prog_addr;
  logic [7:0]        prog_data;
  erase_state_e      erase_st;
  logic [NSECT-1:0]  erase_mask;
  logic              erase_all_prot;
  logic              prog_load, prog_step, prog_expire;
  logic [PW-1:0]     prog_load_val, prog_cnt;
  logic              erase_load, erase_step, erase_expire;
  logic [EW-1:0]     erase_load_val, erase_cnt;

  nbs_op_ctrl #(
    .ADDR_W(ADDR_W), .SECT_W(SECT_W), .PROG_US(PROG_US),
    .PROT_PROG_US(PROT_PROG_US), .ERASE_US(ERASE_US),
    .PROT_ERASE_US(PROT_ERASE_US), .PW(PW), .EW(EW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .prot_map(prot_map),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_sect(cmd_sect),
    .suspend_req(suspend_req), .resume_req(resume_req),
    .prog_expire(prog_expire), .erase_expire(erase_expire),
    .cmd_ready(cmd_ready), .dev_ready(dev_ready),
    .prog_act(prog_act), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_st(erase_st), .erase_mask(erase_mask),
    .erase_all_prot(erase_all_prot),
    .prog_load(prog_load), .prog_load_val(prog_load_val), .prog_step(prog_step),
    .erase_load(erase_load), .erase_load_val(erase_load_val),
    .erase_step(erase_step)
  );

  nbs_tick_timer #(.CNT_W(PW)) u_prog_tmr (
    .clk(clk), .rst_n(rst_n), .load(prog_load), .load_val(prog_load_val),
    .step(prog_step), .cnt(prog_cnt), .expire(prog_expire)
  );

  nbs_tick_timer #(.CNT_W(EW)) u_erase_tmr (
    .clk(clk), .rst_n(rst_n), .load(erase_load), .load_val(erase_load_val),
    .step(erase_step), .cnt(erase_cnt), .expire(erase_expire)
  );

  nbs_read_port #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .prog_act(prog_act), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_st(erase_st), .erase_mask(erase_mask),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .arr_data(arr_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data)
  );
endmodule

// File: rtl/nbs_checker.sv
module nbs_checker
  import nbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SECT_W = 3,
  parameter int EW     = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic                   cmd_ready,
  input logic                   cmd_op,
  input logic                   rd_valid,
  input logic                   rd_ready,
  input logic [ADDR_W-1:0]      rd_addr,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic [7:0]             rsp_data,
  input logic                   dev_ready,
  input logic                   prog_act,
  input logic [ADDR_W-1:0]      prog_addr,
  input logic [7:0]             prog_data,
  input logic [1:0]             erase_st,
  input logic [(1<<SECT_W)-1:0] erase_mask,
  input logic [EW-1:0]          erase_cnt
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (dev_ready && cmd_ready && rd_ready && !rsp_valid));

  p_prog_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == OP_PROG) |=> !dev_ready);

  p_poll_invert_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && prog_act && rd_addr == prog_addr)
      |=> (rsp_data == {~$past(prog_data[7]), 7'b0}));

  p_erase_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !prog_act && erase_st == 2'(E_RUN)
       && erase_mask[rd_addr[ADDR_W-1 -: SECT_W]]) |=> (rsp_data == 8'h00));

  p_susp_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_st == 2'(E_SUSP)) |=> $stable(erase_cnt));

  p_rsp_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

bind nor_busy_status nbs_checker #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .EW(EW)) u_nbs_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
  .dev_ready(dev_ready), .prog_act(prog_act), .prog_addr(prog_addr),
  .prog_data(prog_data), .erase_st(erase_st), .erase_mask(erase_mask),
  .erase_cnt(erase_cnt)
);

// File: tb/tb_nor_busy_status.sv
`timescale 1ns/1ps
module tb_nor_busy_status;
  localparam int AW = 16, SW = 3, NS = 8;
  localparam int P_US = 4, PP_US = 1, E_US = 12, PE_US = 6;

  logic clk = 0, rst_n = 0, us_tick = 0;
  logic [NS-1:0] prot_map = 8'h40;
  logic cmd_valid = 0, cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic [7:0] cmd_data = 0;
  logic [NS-1:0] cmd_sect = 0;
  logic suspend_req = 0, resume_req = 0, rd_valid = 0, rsp_ready = 1;
  logic [AW-1:0] rd_addr = 0;
  logic [7:0] arr_data;
  logic cmd_ready, rd_ready, rsp_valid, dev_ready;
  logic [7:0] rsp_data;

  int checks = 0, errors = 0, cyc = 0;
  bit running = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] arr_of(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign arr_data = arr_of(rd_addr);

  nor_busy_status #(.ADDR_W(AW), .SECT_W(SW), .PROG_US(P_US), .PROT_PROG_US(PP_US),
    .ERASE_US(E_US), .PROT_ERASE_US(PE_US)) dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .prot_map(prot_map),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_sect(cmd_sect),
    .suspend_req(suspend_req), .resume_req(resume_req),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .arr_data(arr_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .dev_ready(dev_ready));

  // environment: tick every 3rd cycle, response back-pressure every 5th cycle
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2;
    us_tick   = (cyc % 3 == 0);
    rsp_ready = (cyc % 5 != 2);
  end

  // behavioural reference model
  bit m_prog, m_pprot, m_rv, m_eall;
  int m_prem, m_est, m_erem;
  logic [AW-1:0] m_paddr;
  logic [7:0] m_pdata, m_rdata;
  logic [NS-1:0] m_emask, m_esel;
  string m_tag = "R1";

  function automatic bit m_cmd_ready();
    return !m_prog && m_est != 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_prog = 0; m_est = 0; m_rv = 0; m_rdata = 0; m_emask = 0; m_esel = 0; m_eall = 0;
    end else begin
      bit o_prog, acc, edone;
      int o_est, s;
      o_prog = m_prog; o_est = m_est;
      acc = cmd_valid && m_cmd_ready();
      s = int'(rd_addr[15:13]);
      if (rd_valid && (!m_rv || rsp_ready)) begin
        m_rv = 1;
        if (m_prog && rd_addr == m_paddr) begin
          m_rdata = {~m_pdata[7], 7'b0};
          m_tag = m_pprot ? "R5" : (m_est == 2 ? "R10" : "R3");
        end else if (m_est == 1 && m_emask[s]) begin
          m_rdata = 8'h00; m_tag = m_eall ? "R7" : "R6";
        end else if (m_est == 2 && m_emask[s]) begin
          m_rdata = 8'h80; m_tag = "R9";
        end else begin
          m_rdata = arr_of(rd_addr);
          m_tag = (m_est != 0 && m_esel[s]) ? "R8" : "R2/R4";
        end
      end else if (rsp_ready) m_rv = 0;
      if (m_prog && us_tick) begin m_prem--; if (m_prem == 0) m_prog = 0; end
      edone = 0;
      if (o_est == 1 && us_tick) begin
        m_erem--; if (m_erem == 0) begin m_est = 0; edone = 1; end
      end
      if (o_est == 1 && !edone && !m_eall && suspend_req) m_est = 2;
      if (o_est == 2 && !o_prog && resume_req && !acc) m_est = 1;   // R11
      if (acc) begin
        if (cmd_op == 1'b0) begin
          m_prog = 1; m_paddr = cmd_addr; m_pdata = cmd_data;
          m_pprot = prot_map[cmd_addr[15:13]];
          m_prem = m_pprot ? PP_US : P_US;
        end else if (o_est == 0) begin
          m_esel = cmd_sect;
          m_emask = cmd_sect & ~prot_map;
          m_eall = (m_emask == 0);
          if (m_eall) m_emask = cmd_sect;
          m_erem = m_eall ? PE_US : E_US;
          m_est = 1;
        end   // erase while suspended is consumed: R10
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (running && rst_n) begin
    chk("R12", int'(dev_ready), int'(m_cmd_ready()));
    chk("R12", int'(cmd_ready), int'(m_cmd_ready()));
    chk("R13", int'(rsp_valid), int'(m_rv));
    chk("R13", int'(rd_ready), int'(!m_rv || rsp_ready));
    if (m_rv) chk(m_tag, int'(rsp_data), int'(m_rdata));
  end

  task automatic step();
    @(posedge clk); #3;
  endtask

  task automatic poll(input logic [AW-1:0] a0, input logic [AW-1:0] a1, input int n);
    for (int i = 0; i < n; i++) begin
      rd_valid = 1; rd_addr = i[0] ? a1 : a0; step();
    end
    rd_valid = 0;
  endtask

  task automatic wait_idle(input logic [AW-1:0] a0, input logic [AW-1:0] a1);
    for (int i = 0; i < 3000 && !dev_ready; i++) begin
      rd_valid = 1; rd_addr = i[0] ? a1 : a0; step();
    end
    rd_valid = 0; step();
  endtask

  task automatic issue(input logic op, input logic [AW-1:0] a, input logic [7:0] d,
                       input logic [NS-1:0] sect);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_sect = sect;
    step();
    cmd_valid = 0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    step();
    // R1 reset state
    chk("R1", int'(dev_ready), 1); chk("R1", int'(cmd_ready), 1);
    chk("R1", int'(rd_ready), 1);  chk("R1", int'(rsp_valid), 0);
    running = 1;
    poll(16'h1234, 16'h8001, 4);
    // R2: read transfers with the program command -> array data
    rd_valid = 1; rd_addr = 16'h2010;
    issue(1'b0, 16'h2010, 8'hA5, 0);
    wait_idle(16'h2010, 16'h2011);           // R3/R4 bit7 of A5 inverted -> 00
    issue(1'b0, 16'h2222, 8'h35, 0);
    wait_idle(16'h2222, 16'h0000);           // status 80
    issue(1'b0, 16'hC123, 8'h12, 0);         // R5 protected sector 6
    wait_idle(16'hC123, 16'hC124);
    issue(1'b1, 0, 0, 8'h06);                // R6 plain erase of sectors 1,2
    wait_idle(16'h2000, 16'h4000);
    issue(1'b1, 0, 0, 8'h44);                // R8 sector 6 protected, 2 erased
    wait_idle(16'hC000, 16'h4100);
    issue(1'b1, 0, 0, 8'h40);                // R7 protected only
    poll(16'hC010, 16'h0010, 3);
    suspend_req = 1; step(); suspend_req = 0;
    wait_idle(16'hC010, 16'hC020);
    issue(1'b1, 0, 0, 8'h30);                // R9 suspend of erase on 4,5
    poll(16'h8000, 16'hA000, 5);
    suspend_req = 1; step(); suspend_req = 0;
    poll(16'h8000, 16'h0100, 6);
    resume_req = 1;                          // R11 ignored: command wins
    issue(1'b0, 16'h0040, 8'hF0, 0);         // R10 program while suspended
    resume_req = 0;
    wait_idle(16'h0040, 16'hA004);
    issue(1'b1, 0, 0, 8'h01);                // R10 erase consumed, no effect
    poll(16'h0000, 16'h8000, 4);
    resume_req = 1; step(); resume_req = 0;  // R11 resume
    wait_idle(16'h8000, 16'hA000);
    poll(16'h8000, 16'h0000, 6);
    running = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule